// File: doc/BRIEF.md
# Multi-Phase Instruction Cycle Sequencer

This block is the control state machine that carries one instruction at a time through up to eight states: fetch, decode, operand address calculation, indirect resolution, operand fetch, execute, result store and interrupt entry. It decides from the decoded instruction class and addressing mode which phases an instruction needs and skips the others. It follows chains of indirect pointers up to a programmable depth. It holds in any phase that waits on memory or on the execute unit until that unit answers. At the end of every instruction it looks at the interrupt request.

The datapath around it supplies the decoded class and mode, the address field, the base and index values for indexed addressing, and the store data. It reads the one-hot phase strobes to steer its own registers. A single memory port serves instruction fetch, pointer reads, operand reads and result writes. The sequencer keeps the program counter, the saved return address, the effective address and the last operand it read.

Top module: `instr_cycle_seq`

## Requirements
- R1: After reset the phase strobe is fetch only (`phase_oh` = 8'h01), `pc` is 0, `err_depth` is 0, and memory is requested for a read at address 0. Strobe bits are 0 fetch, 1 decode, 2 address, 3 indirect, 4 operand, 5 execute, 6 store, 7 interrupt.
- R2: Class 0 (no operation) visits only fetch and decode and then ends. A completed fetch advances `pc` by one.
- R3: Class 1 (register arithmetic) goes from decode straight to execute and then to a one-cycle register store, with no memory access after the fetch.
- R4: Class 2 (memory-operand arithmetic) in mode 1 (direct) passes through address and operand phases and reads the operand at the address field. `opnd` then holds the word that was returned. In mode 0 (register or immediate) it skips both phases, as class 1 does.
- R5: In mode 2 (indexed) the effective address is `idx_base` + `idx_val` + `ir_addr`, modulo 2^AW.
- R6: In mode 3 (indirect) the sequencer reads the word at the current address. Its low AW bits become the next address. When bit AW of that word is set, another read follows. The operand or store phase uses the final address.
- R7: If a flagged word arrives and the number of indirect reads has reached `max_depth`, the instruction ends at once without operand, execute or store phases. `err_depth` is high for exactly one cycle.
- R8: Fetch, indirect, operand and memory store phases hold, and hold their request, until `mem_rdy` is sampled high.
- R9: Execute holds until `exe_done` is sampled high, then moves to the store phase.
- R10: Class 3 (store) computes its address as a class 2 instruction would (mode 0 acts as direct) and skips the operand phase. In the store phase it drives `mem_we` with `mem_addr` set to the effective address and `mem_wdata` set to `st_data`. A register store never raises `mem_req`.
- R11: When `irq` is high at the end of an instruction, one interrupt cycle follows. It saves the next `pc` into `epc` and loads `pc` with the vector VEC. Fetch then resumes at VEC.
- R12: Exactly one strobe is active at any time. A change of phase always moves to a higher strobe bit or returns to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_cls | input | 2 | Decoded instruction class, sampled in decode |
| ir_mode | input | 2 | Addressing mode, sampled in decode |
| ir_addr | input | AW | Address field or offset, sampled in decode |
| idx_base | input | AW | Base register value, sampled in address phase |
| idx_val | input | AW | Index register value, sampled in address phase |
| max_depth | input | DEPW | Limit on indirect reads |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | AW+1 | Memory write data |
| mem_rdata | input | AW+1 | Memory read data; bit AW is the indirect flag |
| mem_rdy | input | 1 | Memory has completed the current request |
| st_data | input | AW+1 | Result to be stored to memory |
| exe_done | input | 1 | Execute unit has finished |
| irq | input | 1 | Interrupt request |
| phase_oh | output | 8 | One-hot phase strobes |
| pc | output | AW | Program counter |
| epc | output | AW | Saved return address |
| opnd | output | AW+1 | Last operand read |
| err_depth | output | 1 | One-cycle pulse on an indirect depth overrun |

## Verification
All strobes and memory controls decode from the phase register. A handshake that is sampled at one rising edge therefore shows its next phase from that edge on. `pc` and `opnd` change at the edge that completes the fetch or operand read. `err_depth` rises at the edge that completes the terminating indirect read, and `pc` equals VEC from the edge that ends the interrupt cycle. The bench drives memory and execute answers and takes its samples on falling edges, where all of these are settled. It logs the sequence of distinct phases, every completed memory transfer and the cycles spent in execute and operand phases. After the return to fetch it compares these logs, `pc`, `epc`, `opnd` and the error pulse count with values worked out from the requirements.

// File: rtl/ics_pkg.sv
package ics_pkg;

  localparam int NPH = 8;

  // encoding order is the phase order; the strobe bit index equals the code
  typedef enum logic [2:0] {
    PH_IF  = 3'd0,
    PH_ID  = 3'd1,
    PH_AC  = 3'd2,
    PH_IND = 3'd3,
    PH_OF  = 3'd4,
    PH_EX  = 3'd5,
    PH_WB  = 3'd6,
    PH_INT = 3'd7
  } phase_e;

  typedef enum logic [1:0] {
    CL_NOP     = 2'd0,
    CL_ALU_REG = 2'd1,
    CL_ALU_MEM = 2'd2,
    CL_STORE   = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    AM_REG = 2'd0,
    AM_DIR = 2'd1,
    AM_IDX = 2'd2,
    AM_IND = 2'd3
  } mode_e;

endpackage

// File: rtl/ics_route.sv
module ics_route
  import ics_pkg::*;
(
  input  phase_e cur,
  input  cls_e   id_cls,
  input  mode_e  id_mode,
  input  cls_e   cls_q,
  input  mode_e  mode_q,
  input  logic   mem_rdy,
  input  logic   ind_flag,
  input  logic   depth_hit,
  input  logic   exe_done,
  input  logic   irq,
  output phase_e nxt,
  output logic   abort
);

  logic   fin;
  phase_e post_ea;

  // after the address is known a store needs no operand read
  assign post_ea = (cls_q == CL_STORE) ? PH_EX : PH_OF;

  always_comb begin
    fin   = 1'b0;
    abort = 1'b0;
    nxt   = cur;
    case (cur)
      PH_IF:  if (mem_rdy) nxt = PH_ID;
      PH_ID: begin
        case (id_cls)
          CL_NOP:     fin = 1'b1;
          CL_ALU_REG: nxt = PH_EX;
          CL_ALU_MEM: nxt = (id_mode == AM_REG) ? PH_EX : PH_AC;
          default:    nxt = PH_AC;
        endcase
      end
      PH_AC:  nxt = (mode_q == AM_IND) ? PH_IND : post_ea;
      PH_IND: begin
        if (mem_rdy) begin
          if (!ind_flag) begin
            nxt = post_ea;
          end else if (depth_hit) begin
            abort = 1'b1;
            fin   = 1'b1;
          end
        end
      end
      PH_OF:  if (mem_rdy) nxt = PH_EX;
      PH_EX:  if (exe_done) nxt = PH_WB;
      PH_WB:  if ((cls_q != CL_STORE) || mem_rdy) fin = 1'b1;
      PH_INT: nxt = PH_IF;
      default: nxt = PH_IF;
    endcase
    // checkpoint between instructions
    if (fin) nxt = irq ? PH_INT : PH_IF;
  end

endmodule

// File: rtl/ics_regs.sv
module ics_regs
  import ics_pkg::*;
#(
  parameter int          AW   = 16,
  parameter int          DEPW = 3,
  parameter int unsigned VEC  = 32'h40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  phase_e          cur,
  input  logic            mem_rdy,
  input  logic [AW:0]     mem_rdata,
  input  logic [1:0]      ir_cls,
  input  logic [1:0]      ir_mode,
  input  logic [AW-1:0]   ir_addr,
  input  logic [AW-1:0]   idx_base,
  input  logic [AW-1:0]   idx_val,
  input  logic [DEPW-1:0] max_depth,
  input  logic            abort,
  output logic [AW-1:0]   pc_q,
  output logic [AW-1:0]   epc_q,
  output logic [AW-1:0]   ea_q,
  output logic [AW:0]     opnd_q,
  output cls_e            cls_q,
  output mode_e           mode_q,
  output logic            ind_flag,
  output logic            depth_hit,
  output logic            err_q
);

  localparam int            DW    = AW + 1;
  localparam logic [AW-1:0] VEC_A = AW'(VEC);

  logic [AW-1:0]   addr_q;
  logic [DEPW-1:0] depth_q;

  logic            pc_en, epc_en, id_en, ea_en, dep_en, op_en;
  logic [AW-1:0]   pc_d, ea_d;
  logic [DEPW-1:0] dep_d;

  assign ind_flag  = mem_rdata[DW-1];
  assign depth_hit = ({1'b0, depth_q} + (DEPW+1)'(1)) >= {1'b0, max_depth};

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc_q;
    if ((cur == PH_IF) && mem_rdy) begin
      pc_en = 1'b1;
      pc_d  = pc_q + 1'b1;
    end else if (cur == PH_INT) begin
      pc_en = 1'b1;
      pc_d  = VEC_A;
    end
  end

  assign epc_en = (cur == PH_INT);
  assign id_en  = (cur == PH_ID);
  assign op_en  = (cur == PH_OF) && mem_rdy;

  always_comb begin
    ea_en  = 1'b0;
    ea_d   = ea_q;
    dep_en = 1'b0;
    dep_d  = depth_q;
    if (cur == PH_AC) begin
      ea_en  = 1'b1;
      ea_d   = (mode_q == AM_IDX) ? (idx_base + idx_val + addr_q) : addr_q;
      dep_en = 1'b1;
      dep_d  = '0;
    end else if ((cur == PH_IND) && mem_rdy) begin
      ea_en  = 1'b1;
      ea_d   = mem_rdata[AW-1:0];
      dep_en = 1'b1;
      dep_d  = depth_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      epc_q   <= '0;
      ea_q    <= '0;
      opnd_q  <= '0;
      addr_q  <= '0;
      depth_q <= '0;
      cls_q   <= CL_NOP;
      mode_q  <= AM_REG;
      err_q   <= 1'b0;
    end else begin
      if (pc_en)  pc_q    <= pc_d;
      if (epc_en) epc_q   <= pc_q;
      if (ea_en)  ea_q    <= ea_d;
      if (dep_en) depth_q <= dep_d;
      if (op_en)  opnd_q  <= mem_rdata;
      if (id_en) begin
        cls_q  <= cls_e'(ir_cls);
        mode_q <= mode_e'(ir_mode);
        addr_q <= ir_addr;
      end
      err_q <= abort;
    end
  end

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import ics_pkg::*;
#(
  parameter int          AW   = 16,
  parameter int          DEPW = 3,
  parameter int unsigned VEC  = 32'h40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ir_cls,
  input  logic [1:0]      ir_mode,
  input  logic [AW-1:0]   ir_addr,
  input  logic [AW-1:0]   idx_base,
  input  logic [AW-1:0]   idx_val,
  input  logic [DEPW-1:0] max_depth,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [AW:0]     mem_wdata,
  input  logic [AW:0]     mem_rdata,
  input  logic            mem_rdy,
  input  logic [AW:0]     st_data,
  input  logic            exe_done,
  input  logic            irq,
  output logic [NPH-1:0]  phase_oh,
  output logic [AW-1:0]   pc,
  output logic [AW-1:0]   epc,
  output logic [AW:0]     opnd,
  output logic            err_depth
);

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  phase_e        phase_q, phase_d;
  cls_e          cls_q;
  mode_e         mode_q;
  logic          ind_flag, depth_hit, abort, wr_phase;
  logic [AW-1:0] ea_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) phase_q <= PH_IF;
    else         phase_q <= phase_d;
  end

  ics_route u_route (
    .cur       (phase_q),
    .id_cls    (cls_e'(ir_cls)),
    .id_mode   (mode_e'(ir_mode)),
    .cls_q     (cls_q),
    .mode_q    (mode_q),
    .mem_rdy   (mem_rdy),
    .ind_flag  (ind_flag),
    .depth_hit (depth_hit),
    .exe_done  (exe_done),
    .irq       (irq),
    .nxt       (phase_d),
    .abort     (abort)
  );

  ics_regs #(.AW(AW), .DEPW(DEPW), .VEC(VEC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cur       (phase_q),
    .mem_rdy   (mem_rdy),
    .mem_rdata (mem_rdata),
    .ir_cls    (ir_cls),
    .ir_mode   (ir_mode),
    .ir_addr   (ir_addr),
    .idx_base  (idx_base),
    .idx_val   (idx_val),
    .max_depth (max_depth),
    .abort     (abort),
    .pc_q      (pc),
    .epc_q     (epc),
    .ea_q      (ea_q),
    .opnd_q    (opnd),
    .cls_q     (cls_q),
    .mode_q    (mode_q),
    .ind_flag  (ind_flag),
    .depth_hit (depth_hit),
    .err_q     (err_depth)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_strobe
    assign phase_oh[g] = (int'(phase_q) == g);
  end

  assign wr_phase  = (phase_q == PH_WB) && (cls_q == CL_STORE);
  assign mem_req   = (phase_q == PH_IF) || (phase_q == PH_IND) ||
                     (phase_q == PH_OF) || wr_phase;
  assign mem_we    = wr_phase;
  assign mem_addr  = (phase_q == PH_IF) ? pc : ea_q;
  assign mem_wdata = st_data;

endmodule

// File: rtl/ics_chk.sv
module ics_chk #(
  parameter int          AW  = 16,
  parameter int unsigned VEC = 32'h40
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    phase_oh,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_rdy,
  input logic          exe_done,
  input logic [AW-1:0] pc,
  input logic          err_depth
);

  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_oh) == 1);

  p_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh != $past(phase_oh)) |-> ((phase_oh > $past(phase_oh)) || (phase_oh == 8'h01)));

  p_if_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh[0] && !mem_rdy) |=> (phase_oh[0] && mem_req));

  p_of_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh[4] && !mem_rdy) |=> (phase_oh[4] && mem_req));

  p_ex_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh[5] && !exe_done) |=> phase_oh[5]);

  p_ex_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh[5] && exe_done) |=> phase_oh[6]);

  p_we_in_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase_oh[6] && mem_req));

  p_wb_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oh[6] && !mem_req) |=> !phase_oh[6]);

  p_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
    phase_oh[7] |=> (phase_oh[0] && (pc == AW'(VEC))));

  p_err_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_depth |-> ($past(phase_oh[3]) && !phase_oh[4] && !phase_oh[5]));

endmodule

bind instr_cycle_seq ics_chk #(.AW(AW), .VEC(VEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .phase_oh  (phase_oh),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_rdy   (mem_rdy),
  .exe_done  (exe_done),
  .pc        (pc),
  .err_depth (err_depth)
);

// File: tb/sim_instr_cycle_seq.sv
`timescale 1ns/1ps
module sim_instr_cycle_seq;

  localparam int AW   = 16;
  localparam int DW   = AW + 1;
  localparam int DEPW = 3;
  localparam int VEC  = 32'h40;

  localparam logic [7:0] S_IF = 8'h01, S_ID = 8'h02, S_AC = 8'h04, S_IND = 8'h08,
                         S_OF = 8'h10, S_EX = 8'h20, S_WB = 8'h40, S_INT = 8'h80;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      ir_cls = '0, ir_mode = '0;
  logic [AW-1:0]   ir_addr = '0, idx_base = '0, idx_val = '0;
  logic [DEPW-1:0] max_depth = '0;
  logic            mem_req, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata;
  logic [DW-1:0]   mem_rdata = '0;
  logic            mem_rdy = 1'b0;
  logic [DW-1:0]   st_data = '0;
  logic            exe_done = 1'b0;
  logic            irq = 1'b0;
  logic [7:0]      phase_oh;
  logic [AW-1:0]   pc, epc;
  logic [DW-1:0]   opnd;
  logic            err_depth;

  always #4 clk = ~clk;

  instr_cycle_seq #(.AW(AW), .DEPW(DEPW), .VEC(VEC)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_cls(ir_cls), .ir_mode(ir_mode), .ir_addr(ir_addr),
    .idx_base(idx_base), .idx_val(idx_val), .max_depth(max_depth),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .st_data(st_data), .exe_done(exe_done),
    .irq(irq), .phase_oh(phase_oh), .pc(pc), .epc(epc), .opnd(opnd), .err_depth(err_depth)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory and execute models, monitor
  logic [DW-1:0] mem [0:255];
  int  lat_fix = -1, ex_fix = -1;
  int  mcnt = 0, mlat = 0, ecnt = 0, elat = 0;
  bit  mfresh = 1, efresh = 1;
  bit  go = 0, armed = 0, done = 0;
  logic [7:0]    ph_log [0:63];
  logic [AW-1:0] ac_addr [0:63];
  bit            ac_we [0:63];
  logic [DW-1:0] ac_wd [0:63];
  int  nph = 0, nacc = 0, nerr = 0, ex_cyc = 0, of_cyc = 0;

  always @(negedge clk) begin
    mem_rdy = 1'b0;
    if (rst_n && mem_req && (!phase_oh[0] || go)) begin
      if (mfresh) begin
        mlat = (lat_fix >= 0) ? lat_fix : int'($urandom % 4);
        mfresh = 0;
        mcnt = 0;
      end
      if (mcnt >= mlat) begin
        mem_rdy = 1'b1;
        mem_rdata = mem[mem_addr[7:0]];
        if (nacc < 64) begin
          ac_addr[nacc] = mem_addr;
          ac_we[nacc]   = mem_we;
          ac_wd[nacc]   = mem_wdata;
        end
        nacc++;
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        if (phase_oh[0]) go = 0;
        mfresh = 1;
      end else begin
        mcnt++;
      end
    end
    exe_done = 1'b0;
    if (phase_oh[5]) begin
      ex_cyc++;
      if (efresh) begin
        elat = (ex_fix >= 0) ? ex_fix : int'($urandom % 5);
        efresh = 0;
        ecnt = 0;
      end
      if (ecnt >= elat) begin
        exe_done = 1'b1;
        efresh = 1;
      end else begin
        ecnt++;
      end
    end
    if (phase_oh[4]) of_cyc++;
    if (err_depth) nerr++;
    if (armed) begin
      if (nph == 0 || ph_log[nph-1] != phase_oh) begin
        if (nph < 64) ph_log[nph] = phase_oh;
        nph++;
        if (phase_oh == S_IF && nph > 1) begin
          done  = 1;
          armed = 0;
        end
      end
    end
  end

  // expected values
  logic [7:0]    eph [0:31];
  logic [AW-1:0] ea_addr [0:31];
  bit            ea_we [0:31];
  logic [DW-1:0] ea_wd [0:31];
  int            ne = 0, nea = 0;
  bit            e_err, e_of;
  logic [DW-1:0] e_opnd;
  logic [AW-1:0] pc_m = '0;

  task automatic push_ph(input logic [7:0] p);
    eph[ne] = p;
    ne++;
  endtask

  task automatic push_acc(input logic [AW-1:0] a, input bit w, input logic [DW-1:0] d);
    ea_addr[nea] = a;
    ea_we[nea]   = w;
    ea_wd[nea]   = d;
    nea++;
  endtask

  task automatic build_exp(input int cls, input int mode, input logic [AW-1:0] addr,
                           input logic [AW-1:0] base, input logic [AW-1:0] idx,
                           input int maxd, input bit irqv, input logic [DW-1:0] sd);
    logic [AW-1:0] ea;
    logic [DW-1:0] w;
    int  n;
    bit  stop, walk;
    ne = 0; nea = 0; e_err = 0; e_of = 0; e_opnd = '0;
    push_ph(S_IF);
    push_acc(pc_m, 0, '0);
    push_ph(S_ID);
    if (cls != 0) begin
      if (cls == 1 || (cls == 2 && mode == 0)) begin
        push_ph(S_EX);
        push_ph(S_WB);
      end else begin
        push_ph(S_AC);
        ea = (mode == 2) ? AW'(base + idx + addr) : addr;
        stop = 0;
        if (mode == 3) begin
          push_ph(S_IND);
          n = 0;
          walk = 1;
          while (walk) begin
            w = mem[ea[7:0]];
            push_acc(ea, 0, '0);
            n++;
            ea = w[AW-1:0];
            if (!w[DW-1]) walk = 0;
            else if (n >= maxd) begin
              walk = 0;
              stop = 1;
              e_err = 1;
            end
          end
        end
        if (!stop) begin
          if (cls == 3) begin
            push_ph(S_EX);
            push_ph(S_WB);
            push_acc(ea, 1, sd);
          end else begin
            push_ph(S_OF);
            push_acc(ea, 0, '0);
            e_of = 1;
            e_opnd = mem[ea[7:0]];
            push_ph(S_EX);
            push_ph(S_WB);
          end
        end
      end
    end
    if (irqv) push_ph(S_INT);
    push_ph(S_IF);
  endtask

  task automatic run_instr(input string tag, input int cls, input int mode,
                           input logic [AW-1:0] addr, input logic [AW-1:0] base,
                           input logic [AW-1:0] idx, input int maxd, input bit irqv,
                           input logic [DW-1:0] sd);
    logic [AW-1:0] pc_next;
    build_exp(cls, mode, addr, base, idx, maxd, irqv, sd);
    pc_next   = pc_m + 1'b1;
    ir_cls    = 2'(cls);
    ir_mode   = 2'(mode);
    ir_addr   = addr;
    idx_base  = base;
    idx_val   = idx;
    max_depth = DEPW'(maxd);
    irq       = irqv;
    st_data   = sd;
    nph = 0; nacc = 0; nerr = 0; ex_cyc = 0; of_cyc = 0;
    done = 0;
    armed = 1;
    go = 1;
    for (int k = 0; k < 400 && !done; k++) begin
      @(posedge clk);
      #1;
    end
    irq = 1'b0;
    chk(done, tag, "instruction completion", done, 1);
    chk(nph == ne, tag, "phase count", nph, ne);
    for (int i = 0; i < ne && i < nph; i++)
      chk(ph_log[i] == eph[i], tag, $sformatf("phase step %0d", i), ph_log[i], eph[i]);
    chk(nacc == nea, tag, "memory transfer count", nacc, nea);
    for (int i = 0; i < nea && i < nacc; i++) begin
      chk(ac_addr[i] == ea_addr[i], tag, $sformatf("transfer %0d address", i), ac_addr[i], ea_addr[i]);
      chk(ac_we[i] == ea_we[i], tag, $sformatf("transfer %0d write", i), ac_we[i], ea_we[i]);
      if (ea_we[i])
        chk(ac_wd[i] == ea_wd[i], tag, $sformatf("transfer %0d data", i), ac_wd[i], ea_wd[i]);
    end
    chk(nerr == int'(e_err), "R7", "depth error pulses", nerr, e_err);
    if (e_of) chk(opnd == e_opnd, tag, "operand", opnd, e_opnd);
    if (irqv) begin
      chk(epc == pc_next, "R11", "saved return address", epc, pc_next);
      pc_m = AW'(VEC);
    end else begin
      pc_m = pc_next;
    end
    chk(pc == pc_m, tag, "program counter", pc, pc_m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++)
      mem[i] = {1'b0, 16'(i * 37 + 5)};
    mem[8'h10] = {1'b1, 16'h0020};
    mem[8'h20] = {1'b1, 16'h0030};
    mem[8'h30] = {1'b0, 16'h0044};
    mem[8'h44] = {1'b0, 16'h1234};
    mem[8'h50] = {1'b0, 16'hbeef};

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk(phase_oh == S_IF, "R1", "strobe after reset", phase_oh, S_IF);
    chk(pc == '0, "R1", "pc after reset", pc, 0);
    chk(err_depth == 1'b0, "R1", "error after reset", err_depth, 0);
    chk(mem_req && !mem_we && mem_addr == '0, "R1", "fetch request at 0",
        {mem_req, mem_we, mem_addr}, 18'h20000);

    run_instr("R2", 0, 1, 16'h0050, '0, '0, 3, 0, '0);
    run_instr("R3", 1, 2, 16'h0050, 16'h1, 16'h2, 3, 0, '0);
    run_instr("R4", 2, 1, 16'h0050, '0, '0, 3, 0, '0);
    run_instr("R4", 2, 0, 16'h0050, '0, '0, 3, 0, '0);
    run_instr("R5", 2, 2, 16'h0040, 16'h0003, 16'h0001, 3, 0, '0);
    run_instr("R5", 2, 2, 16'hffff, 16'h0020, 16'h0031, 3, 0, '0);
    run_instr("R6", 2, 3, 16'h0010, '0, '0, 5, 0, '0);
    run_instr("R7", 2, 3, 16'h0010, '0, '0, 2, 0, '0);
    run_instr("R7", 3, 3, 16'h0010, '0, '0, 1, 1, 17'h0abcd);
    run_instr("R10", 3, 1, 16'h0060, '0, '0, 3, 0, 17'h1c0de);
    run_instr("R10", 3, 3, 16'h0010, '0, '0, 4, 0, 17'h05555);
    run_instr("R11", 0, 0, 16'h0000, '0, '0, 3, 1, '0);
    run_instr("R11", 2, 1, 16'h0050, '0, '0, 3, 1, '0);

    // R8 and R9: fixed waits
    lat_fix = 3;
    ex_fix  = 6;
    run_instr("R8", 2, 1, 16'h0050, '0, '0, 3, 0, '0);
    chk(of_cyc == 4, "R8", "cycles in operand phase", of_cyc, 4);
    chk(ex_cyc == 7, "R9", "cycles in execute phase", ex_cyc, 7);
    lat_fix = -1;
    ex_fix  = -1;

    // random mix, mostly checking R12 ordering and skipping
    for (int i = 0; i < 256; i++)
      if ($urandom % 3 == 0) mem[i] = {1'b1, 8'h00, 8'($urandom)};
    for (int t = 0; t < 60; t++) begin
      run_instr("R12", int'($urandom % 4), int'($urandom % 4), 16'($urandom),
                16'($urandom), 16'($urandom), int'($urandom % 6),
                ($urandom % 5) == 0, 17'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule